// File: doc/BRIEF.md
# Racing-Counter Oscillator Tamper Monitor

This block watches two free-running sensor oscillators and does not use a frequency reference. Each oscillator is divided by four. The two divided clocks advance two counters, and the counters race each other. A race ends as soon as one counter reaches its terminal count. The count the other counter has reached at that moment measures how far apart the two frequencies are. With no probe nearby, the two oscillators run within a fraction of a percent of each other. A probe brought close to one coil pulls that oscillator by several percent, and the monitor flags this as tampering.

After `start_i`, the block first trims the capacitor code of oscillator B against oscillator A. Oscillator A's code is held at mid-scale. The trim is a successive-approximation search that takes one race per code bit. After the search the code is frozen, `cal_done_o` rises and the block races continuously. A run of consecutive races whose mismatch exceeds `threshold_i` sets a sticky alarm. The alarm stays set until reset. The oscillators are enabled only while the block is active. The analog tanks and the capacitor bank sit outside the block and are driven by the trim and enable outputs.

Top module: `race_tamper_monitor`

## Requirements
- R1: After reset, and until `start_i` is seen, `alarm_o`, `cal_done_o`, both oscillator enables and `trim_b_o` are all 0.
- R2: From one clock after `start_i`, both oscillator enables are 1 and stay 1 until reset.
- R3: `trim_a_o` is always mid-scale (2^(N-1)). During calibration the first code tried on B is the MSB alone. A trial bit is kept when B's counter wins the race, and bits are decided from MSB down to LSB.
- R4: After calibration, `trim_b_o` is within one step of the largest code at which B still runs faster than A.
- R5: `cal_done_o` rises after N races and stays high. From then on `trim_b_o` does not change until reset.
- R6: A race counts rising edges of each oscillator divided by 4. It ends when either count reaches 2^K. Its mismatch is 2^K minus the other count, or 0 if both counts reach 2^K together. A race is over threshold when the mismatch is strictly greater than `threshold_i`, and the threshold is sampled at the end of each race.
- R7: The alarm sets only after CONSEC (default 2) back-to-back monitoring races are over threshold. Any race at or below threshold restarts the run.
- R8: Once set, `alarm_o` stays at 1 until reset, even after the mismatch disappears.
- R9: After calibration, a 1% mismatch in either direction, with threshold 7, does not set the alarm.
- R10: After calibration, a 5% frequency shift of either oscillator, with threshold 7, sets the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin calibration, then monitoring |
| threshold_i | input | K+1 | Allowed race mismatch in divided ticks |
| osc_a_i | input | 1 | Sensor oscillator A |
| osc_b_i | input | 1 | Sensor oscillator B |
| osc_a_en_o | output | 1 | Enable for oscillator A |
| osc_b_en_o | output | 1 | Enable for oscillator B |
| trim_a_o | output | N | Capacitor code of A (fixed mid-scale) |
| trim_b_o | output | N | Capacitor code of B |
| cal_done_o | output | 1 | Calibration finished, monitoring active |
| alarm_o | output | 1 | Sticky tamper alarm |

## Verification
The oscillator models scale their periods with their trim codes. Calibration is swept over three starting mismatches of B, which shows whether the search lands on the arithmetically predicted code from different sides. Monitoring is then run with B detuned by +1% and by -1%, which must stay quiet, and with A and then B pulled by 5%, which must alarm. This separates threshold margin from detection on either side. A probe window shorter than two races checks the consecutive-race filter. Removing the probe checks stickiness. A maximum threshold followed by a runtime change to 7 shows that the comparison follows `threshold_i`.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_RUN,
    ST_EVAL
  } race_st_e;
endpackage

// File: rtl/rtm_prediv.sv
// Divides one oscillator by 4 in its own domain, then brings the divided
// level into the system domain and emits a one-cycle tick per rising edge.
module rtm_prediv #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  output logic tick_o
);
  logic [1:0]    div_q;
  logic [SYNC:0] sync_q;

  always_ff @(posedge osc_i or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-1:0], div_q[1]};
  end

  assign tick_o = sync_q[SYNC-1] & ~sync_q[SYNC];
endmodule

// File: rtl/rtm_race_counter.sv
module rtm_race_counter #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [K:0]   cnt_o,
  output logic         term_o
);
  localparam int CW = K + 1;
  localparam logic [CW-1:0] TERM = CW'(1) << K;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (run_i && tick_i && !term_o) cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o  = cnt_q;
  assign term_o = (cnt_q == TERM);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TERM);
  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtm_race_ctrl.sv
module rtm_race_ctrl
  import rtm_pkg::*;
#(
  parameter int N      = 6,
  parameter int K      = 8,
  parameter int CONSEC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [K:0]   threshold_i,
  input  logic [K:0]   cnt_a_i,
  input  logic [K:0]   cnt_b_i,
  input  logic         term_a_i,
  input  logic         term_b_i,
  output logic         clr_o,
  output logic         run_o,
  output logic         osc_en_o,
  output logic [N-1:0] trim_b_o,
  output logic         cal_done_o,
  output logic         alarm_o
);
  localparam int CW = K + 1;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int SW = $clog2(CONSEC + 1);
  localparam logic [CW-1:0] TERM = CW'(1) << K;

  race_st_e      st_q;
  logic          cal_q, done_q, alarm_q;
  logic [IW-1:0] idx_q;
  logic [N-1:0]  code_q, bit_mask;
  logic [SW-1:0] streak_q;
  logic [CW-1:0] gap;
  logic          b_wins, over;

  always_comb begin
    if (term_a_i && term_b_i) gap = '0;
    else if (term_a_i)        gap = TERM - cnt_b_i;
    else                      gap = TERM - cnt_a_i;
  end

  assign b_wins   = term_b_i && !term_a_i;
  assign over     = gap > threshold_i;
  assign bit_mask = N'(1) << idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cal_q    <= 1'b0;
      done_q   <= 1'b0;
      alarm_q  <= 1'b0;
      idx_q    <= '0;
      code_q   <= '0;
      streak_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_CLEAR;
          cal_q  <= 1'b1;
          idx_q  <= IW'(N - 1);
          code_q <= '0;
        end
        ST_CLEAR: st_q <= ST_RUN;
        ST_RUN:   if (term_a_i || term_b_i) st_q <= ST_EVAL;
        ST_EVAL: begin
          st_q <= ST_CLEAR;
          if (cal_q) begin
            if (b_wins) code_q <= code_q | bit_mask;
            if (idx_q == '0) begin
              cal_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q - IW'(1);
            end
          end else if (over) begin
            if (int'(streak_q) + 1 >= CONSEC) alarm_q <= 1'b1;
            if (int'(streak_q) < CONSEC) streak_q <= streak_q + SW'(1);
          end else begin
            streak_q <= '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_o      = (st_q == ST_CLEAR);
  assign run_o      = (st_q == ST_RUN);
  assign osc_en_o   = (st_q != ST_IDLE);
  assign trim_b_o   = cal_q ? (code_q | bit_mask) : code_q;
  assign cal_done_o = done_q;
  assign alarm_o    = alarm_q;

  assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> alarm_o);
  assert_code_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> (cal_done_o && $stable(trim_b_o)));
  assert_alarm_after_cal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> cal_done_o);
  assert_alarm_on_eval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> $past(st_q) == ST_EVAL);
  assert_race_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && (term_a_i || term_b_i)) |=> st_q == ST_EVAL);
  assert_en_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en_o |=> osc_en_o);
endmodule

// File: rtl/race_tamper_monitor.sv
module race_tamper_monitor #(
  parameter int N      = 6,
  parameter int K      = 8,
  parameter int CONSEC = 2,
  parameter int SYNC   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [K:0]   threshold_i,
  input  logic         osc_a_i,
  input  logic         osc_b_i,
  output logic         osc_a_en_o,
  output logic         osc_b_en_o,
  output logic [N-1:0] trim_a_o,
  output logic [N-1:0] trim_b_o,
  output logic         cal_done_o,
  output logic         alarm_o
);
  localparam logic [N-1:0] MID = N'(1) << (N - 1);

  logic [1:0] osc_v, tick_v, term_v;
  logic [K:0] cnt_v [2];
  logic       clr, run, osc_en;

  assign osc_v = {osc_b_i, osc_a_i};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    rtm_prediv #(.SYNC(SYNC)) prediv_i (
      .clk(clk), .rst_n(rst_n), .osc_i(osc_v[g]), .tick_o(tick_v[g])
    );
    rtm_race_counter #(.K(K)) counter_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .run_i(run),
      .tick_i(tick_v[g]), .cnt_o(cnt_v[g]), .term_o(term_v[g])
    );
  end

  rtm_race_ctrl #(.N(N), .K(K), .CONSEC(CONSEC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .threshold_i(threshold_i),
    .cnt_a_i(cnt_v[0]), .cnt_b_i(cnt_v[1]),
    .term_a_i(term_v[0]), .term_b_i(term_v[1]),
    .clr_o(clr), .run_o(run), .osc_en_o(osc_en),
    .trim_b_o(trim_b_o), .cal_done_o(cal_done_o), .alarm_o(alarm_o)
  );

  assign osc_a_en_o = osc_en;
  assign osc_b_en_o = osc_en;
  assign trim_a_o   = MID;
endmodule

// File: tb/race_tamper_monitor_tb_top.sv
`timescale 1ns/1ps
module race_tamper_monitor_tb_top;
  localparam int  N      = 6;
  localparam int  K      = 8;
  localparam int  MID    = 1 << (N - 1);
  localparam real STEP   = 0.005;
  localparam real BASE_A = 9.0;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [K:0] thr = 9'd7;
  logic osc_a = 1'b0, osc_b = 1'b0;
  logic en_a, en_b, cal_done, alarm;
  logic [N-1:0] trim_a, trim_b;
  real base_b = 9.3, probe_a = 1.0, probe_b = 1.0;
  int  tests = 0, fails = 0;

  always #4 clk = ~clk;

  always begin
    if (en_a === 1'b1) begin
      #(BASE_A * (1.0 + STEP * real'(trim_a)) * probe_a / 2.0) osc_a = ~osc_a;
    end else begin
      osc_a = 1'b0;
      @(en_a);
    end
  end

  always begin
    if (en_b === 1'b1) begin
      #(base_b * (1.0 + STEP * real'(trim_b)) * probe_b / 2.0) osc_b = ~osc_b;
    end else begin
      osc_b = 1'b0;
      @(en_b);
    end
  end

  race_tamper_monitor #(.N(N), .K(K), .CONSEC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .threshold_i(thr),
    .osc_a_i(osc_a), .osc_b_i(osc_b), .osc_a_en_o(en_a), .osc_b_en_o(en_b),
    .trim_a_o(trim_a), .trim_b_o(trim_b), .cal_done_o(cal_done), .alarm_o(alarm)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start = 1'b0;
    probe_a = 1.0; probe_b = 1.0;
    clks(3); rst_n = 1'b1; clks(2);
  endtask

  task automatic kick();
    start = 1'b1; clks(1); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !cal_done; i++) clks(1);
  endtask

  task automatic wait_alarm(input int lim);
    for (int i = 0; i < lim && !alarm; i++) clks(1);
  endtask

  function automatic int ideal_code(input real bb);
    int  r  = 0;
    real ta = BASE_A * (1.0 + STEP * MID);
    for (int c = 0; c < (1 << N); c++)
      if (bb * (1.0 + STEP * c) < ta) r = c;
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int code_keep;
    clks(3);
    // R1: reset state
    check("R1 alarm", alarm, 0);
    check("R1 cal_done", cal_done, 0);
    check("R1 enables", {en_a, en_b}, 0);
    check("R1 trim_b", trim_b, 0);
    rst_n = 1'b1; clks(5);
    check("R1 idle enables", {en_a, en_b}, 0);

    // calibration sweep over starting mismatches of B
    for (int i = 0; i < 3; i++) begin
      int d;
      do_reset();
      base_b = 9.3 + 0.3 * i;
      kick();
      clks(2);
      check("R2 enables", {en_a, en_b}, 3);
      check("R3 trim_a mid", trim_a, MID);
      check("R3 first trial", trim_b, MID);
      wait_done();
      check("R5 cal_done", cal_done, 1);
      d = int'(trim_b) - ideal_code(base_b);
      if (d < 0) d = -d;
      check("R4 code within 1", (d <= 1) ? 1 : 0, 1);
      check("R9 no alarm matched", alarm, 0);
    end

    code_keep = trim_b;
    clks(3000);
    check("R5 code frozen", trim_b, code_keep);
    check("R2 enables held", {en_a, en_b}, 3);

    probe_b = 1.01; clks(8000);
    check("R9 +1% no alarm", alarm, 0);
    probe_b = 0.99; clks(8000);
    check("R9 -1% no alarm", alarm, 0);

    // short probe window (< 2 races) must not alarm
    probe_b = 1.0; probe_a = 1.05; clks(1000);
    probe_a = 1.0;
    check("R7 single race", alarm, 0);
    clks(6000);
    check("R7 run restarted", alarm, 0);

    probe_a = 1.05; clks(1000);
    check("R7 not yet", alarm, 0);
    wait_alarm(12000);
    check("R10 A shift alarm", alarm, 1);
    probe_a = 1.0; clks(6000);
    check("R8 sticky", alarm, 1);

    do_reset();
    check("R8 reset clears", alarm, 0);
    kick(); wait_done();
    probe_b = 1.05;
    wait_alarm(12000);
    check("R10 B shift alarm", alarm, 1);

    // threshold at its maximum blocks the alarm; lowering it enables it
    do_reset();
    thr = 9'd256;
    kick(); wait_done();
    probe_a = 1.05; clks(8000);
    check("R6 max threshold", alarm, 0);
    thr = 9'd7;
    wait_alarm(12000);
    check("R6 threshold lowered", alarm, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule